// File: doc/BRIEF.md
# Power-Down and Lock-Acquisition Output Gate

This block sits between the parallel side of a 21-bit receive path and the pins that leave the chip. It decides, from an active-low power-down input and a lock counter, which of three states the outputs are in. In power-down the data and clock outputs are released to high impedance. After power-up they are actively held low while a fixed-length count runs in place of a lock detector. Once the count completes, registered receive data and a strobe clock are passed through. The 21 data bits form three 7-bit lanes (bits 0–6, 7–13, 14–20), and all three lanes are gated the same way.

The release to high impedance does not wait for a clock edge. The drive enable returns only after the power-down input has passed a two-flop synchroniser. Because of this asymmetry, two instances can share one output bus as a 2:1 mux that is selected by their power-down inputs. A second, free-running monitor clock watches the reference clock. If the reference clock stops for too long, lock is withdrawn, and the count starts over once the clock comes back. A build parameter chooses whether the downstream stage should capture on the rising or the falling edge of the output clock.

Top module: `rx_out_gate`

## Requirements
- R1: While `pdn_n` is low, `q_data_oe`, `q_clk_oe` and `locked` are all 0. This is also the state of the outputs after `rst_n` has been low at a `ref_clk` rising edge, with `pdn_n` low.
- R2: A falling `pdn_n` clears `q_data_oe`, `q_clk_oe` and `locked` without waiting for any clock edge.
- R3: After `pdn_n` rises, the enables stay 0 after the first `ref_clk` rising edge and are 1 after the second. While the enables are 1 and `locked` is 0, `q_data` is all zeros and `q_clk` is 0.
- R4: `locked` goes to 1 right after `ref_clk` rising edge number 2+LOCK_CYCLES, counted from the rise of `pdn_n`. It is 0 after every earlier edge.
- R5: While `locked` is 1, `q_data` equals the value `rx_data` had at the previous `ref_clk` rising edge, bit for bit across all three lanes.
- R6: With STROBE_FALL=0, a locked `q_clk` is the inverse of `ref_clk`, so its rising edge falls mid-data. With STROBE_FALL=1, a locked `q_clk` follows `ref_clk`, so its falling edge falls mid-data.
- R7: Taking `pdn_n` low, whether during the count or after lock, discards all progress. The next power-up again needs the full 2+LOCK_CYCLES edges.
- R8: If `ref_clk` stops for more than STALL_LIMIT `mon_clk` cycles while `pdn_n` is high, `locked` drops to 0, `q_data` and `q_clk` read 0, and the enables stay 1. After the clock returns, `locked` stays 0 for more than LOCK_CYCLES+2 rising edges and then returns to 1.
- R9: When two instances drive one bus and one `pdn_n` is lowered before the other is raised, the two `q_data_oe` outputs are never 1 together. The bus then carries the data of the enabled instance.
- R10: `rst_n` is synchronous and active-low. Sampled low at a `ref_clk` rising edge, it clears `locked` and the enables. After release, lock again follows the R4 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Parallel-rate reference clock |
| mon_clk | input | 1 | Free-running clock, faster than ref_clk, used to detect a stopped ref_clk |
| rst_n | input | 1 | Synchronous active-low reset, held across edges of both clocks |
| pdn_n | input | 1 | Active-low power-down, asynchronous to both clocks |
| rx_data | input | 21 | Parallel data from the receive path, three 7-bit lanes |
| q_data | output | 21 | Gated output data |
| q_data_oe | output | 1 | Tri-state enable for q_data |
| q_clk | output | 1 | Gated output strobe clock |
| q_clk_oe | output | 1 | Tri-state enable for q_clk |
| locked | output | 1 | Lock counter complete and outputs live |

## Verification
The hardest condition to reach is a stalled reference clock while the monitor clock keeps running. Reaching it takes a clock generator that can be frozen in its low phase at a chosen edge. The bench stops the reference clock of a locked instance for many monitor cycles and checks that the outputs are held low but still driven. It then restarts the clock off the edge grid and checks that the lock count starts over from zero rather than resuming. The two-instance bus handover is observed by an independent sampler at odd nanoseconds, clear of every clock edge.

// File: rtl/rxg_pkg.sv
// Shared constants and types for the output gate.
// Assumes: lane structure is fixed at three lanes of seven bits.
package rxg_pkg;
    localparam int LANE_W = 7;
    localparam int LANES  = 3;
    localparam int DATA_W = LANE_W * LANES;

    // Output behaviour selected by power and lock state.
    typedef enum logic [1:0] {
        GATE_OFF  = 2'd0,
        GATE_ACQ  = 2'd1,
        GATE_LIVE = 2'd2
    } gate_mode_e;
endpackage

// File: rtl/rxg_sync2.sv
// Two-flop synchroniser for a single-bit level crossing into clk.
// Assumes: input is a level held for several destination cycles.
module rxg_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    // Capture the asynchronous level through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rxg_lock_ctr.sv
// Lock-time counter standing in for a lock detector.
// Counts reference edges while run is high and sets lock_q after
// LOCK_CYCLES of them. Dropping run clears everything on the next edge.
// Assumes: run is synchronous to clk.
module rxg_lock_ctr #(
    parameter int LOCK_CYCLES = 32800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic lock_q
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Advance the count until the terminal value, then hold lock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt    <= '0;
            lock_q <= 1'b0;
        end else if (!lock_q) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
                lock_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxg_clk_watch.sv
// Reference-clock stall detector in the monitor clock domain.
// A toggle from the reference domain is synchronised. If it holds still
// for STALL_LIMIT monitor cycles, stalled is set. stalled clears only
// after the reference domain has acknowledged it, which requires the
// reference clock to be running again.
// Assumes: mon_clk period is well under the ref_clk period.
module rxg_clk_watch #(
    parameter int STALL_LIMIT = 64
) (
    input  logic mon_clk,
    input  logic rst_n,
    input  logic ref_tgl,
    input  logic ack,
    output logic stalled
);
    localparam int IDLE_W = $clog2(STALL_LIMIT + 1);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(STALL_LIMIT - 1);

    logic              tgl_s;
    logic              tgl_d;
    logic              ack_s;
    logic              seen;
    logic [IDLE_W-1:0] idle;

    rxg_sync2 #(.RST_VAL(1'b0)) u_tgl_sync (
        .clk(mon_clk), .rst_n(rst_n), .d(ref_tgl), .q(tgl_s)
    );
    rxg_sync2 #(.RST_VAL(1'b0)) u_ack_sync (
        .clk(mon_clk), .rst_n(rst_n), .d(ack), .q(ack_s)
    );

    // Activity on the reference side, seen as a toggle change.
    always_comb seen = tgl_s ^ tgl_d;

    // Measure quiet time and manage the stall flag handshake.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            tgl_d   <= 1'b0;
            idle    <= '0;
            stalled <= 1'b0;
        end else begin
            tgl_d <= tgl_s;
            if (stalled) begin
                idle <= '0;
                if (ack_s) begin
                    stalled <= 1'b0;
                end
            end else if (seen) begin
                idle <= '0;
            end else if (idle == IDLE_LAST) begin
                idle    <= '0;
                stalled <= 1'b1;
            end else begin
                idle <= idle + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxg_lane.sv
// One data lane: registers the incoming bits on the reference edge and
// forces them to zero unless the gate is live.
// Assumes: live is glitch-tolerant at the pins (a tri-state output).
module rxg_lane #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic         live,
    output logic [W-1:0] q
);
    logic [W-1:0] d_q;

    // Launch lane data on the reference rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d;
        end
    end

    // Hold the lane low until the gate is live.
    always_comb q = live ? d_q : '0;
endmodule

// File: rtl/rx_out_gate.sv
// Output gate for a 21-bit parallel receiver.
// States: released (power-down), driven low (lock count running) and
// live. Power-down removes the drive asynchronously. Drive returns only
// after pdn_n is synchronised. A stalled ref_clk, detected in the
// mon_clk domain, withdraws lock and restarts the count.
// Assumes: rst_n is held across several edges of both clocks.
module rx_out_gate
    import rxg_pkg::*;
#(
    parameter int LOCK_CYCLES = 32800,
    parameter int STALL_LIMIT = 64,
    parameter bit STROBE_FALL = 1'b0
) (
    input  logic              ref_clk,
    input  logic              mon_clk,
    input  logic              rst_n,
    input  logic              pdn_n,
    input  logic [DATA_W-1:0] rx_data,
    output logic [DATA_W-1:0] q_data,
    output logic              q_data_oe,
    output logic              q_clk,
    output logic              q_clk_oe,
    output logic              locked
);
    logic       pdn_s;
    logic       stall_s;
    logic       stalled;
    logic       ref_tgl;
    logic       run;
    logic       lock_q;
    logic       ack;
    logic       drive;
    logic       live;
    logic       strobe_src;
    gate_mode_e mode;

    rxg_sync2 #(.RST_VAL(1'b0)) u_pdn_sync (
        .clk(ref_clk), .rst_n(rst_n), .d(pdn_n), .q(pdn_s)
    );
    rxg_sync2 #(.RST_VAL(1'b0)) u_stall_sync (
        .clk(ref_clk), .rst_n(rst_n), .d(stalled), .q(stall_s)
    );

    // Free-running toggle that proves the reference clock is alive.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            ref_tgl <= 1'b0;
        end else begin
            ref_tgl <= ~ref_tgl;
        end
    end

    rxg_clk_watch #(.STALL_LIMIT(STALL_LIMIT)) u_watch (
        .mon_clk(mon_clk), .rst_n(rst_n), .ref_tgl(ref_tgl),
        .ack(ack), .stalled(stalled)
    );

    // Count only when powered and the clock has not been flagged stalled.
    always_comb run = pdn_s & ~stall_s;
    // Acknowledge a stall only once the lock flag has been cleared.
    always_comb ack = stall_s & ~lock_q;

    rxg_lock_ctr #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk(ref_clk), .rst_n(rst_n), .run(run), .lock_q(lock_q)
    );

    // Select output behaviour; the raw pdn_n gives the instant release.
    always_comb begin
        if (!(pdn_n && pdn_s)) begin
            mode = GATE_OFF;
        end else if (lock_q && !stalled) begin
            mode = GATE_LIVE;
        end else begin
            mode = GATE_ACQ;
        end
    end

    always_comb drive = (mode != GATE_OFF);
    always_comb live  = (mode == GATE_LIVE);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rxg_lane #(.W(LANE_W)) u_lane (
            .clk  (ref_clk),
            .rst_n(rst_n),
            .d    (rx_data[g*LANE_W +: LANE_W]),
            .live (live),
            .q    (q_data[g*LANE_W +: LANE_W])
        );
    end

    if (STROBE_FALL) begin : g_fall
        // Falling strobe edge sits mid-data: pass the reference through.
        assign strobe_src = ref_clk;
    end else begin : g_rise
        // Rising strobe edge sits mid-data: invert the reference.
        assign strobe_src = ~ref_clk;
    end

    always_comb q_clk     = live & strobe_src;
    always_comb q_data_oe = drive;
    always_comb q_clk_oe  = drive;
    always_comb locked    = live;
endmodule

// File: rtl/rxg_checker.sv
// Temporal checks on the output gate, bound into every instance.
// Assumes: sampled on ref_clk; silent while rst_n is low.
module rxg_checker #(
    parameter int DATA_W = 21
) (
    input logic              ref_clk,
    input logic              rst_n,
    input logic              pdn_n,
    input logic [DATA_W-1:0] rx_data,
    input logic [DATA_W-1:0] q_data,
    input logic              q_data_oe,
    input logic              q_clk,
    input logic              q_clk_oe,
    input logic              locked,
    input logic              lock_q,
    input logic              run
);
    p_hiz_pd_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !pdn_n |-> (!q_data_oe && !q_clk_oe && !locked));

    p_low_acq_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (q_data_oe && !locked) |-> (q_data == '0 && !q_clk));

    p_oe_after_sync_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(q_data_oe) |-> $past(pdn_n, 2));

    p_lock_needs_run_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(run));

    p_live_driven_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        locked |-> q_data_oe);

    p_data_follow_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> (q_data == $past(rx_data)));
endmodule

bind rx_out_gate rxg_checker #(.DATA_W(rxg_pkg::DATA_W)) u_chk (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .pdn_n    (pdn_n),
    .rx_data  (rx_data),
    .q_data   (q_data),
    .q_data_oe(q_data_oe),
    .q_clk    (q_clk),
    .q_clk_oe (q_clk_oe),
    .locked   (locked),
    .lock_q   (lock_q),
    .run      (run)
);

// File: tb/sim_rx_out_gate.sv
// Bench: two instances sharing one bus, small lock and stall limits.
module sim_rx_out_gate;
    localparam int L  = 8;
    localparam int SL = 8;
    localparam int DW = 21;

    logic          ref_clk = 1'b0;
    logic          mon_clk = 1'b0;
    logic          ref_run = 1'b1;
    logic          rst_n   = 1'b0;
    logic          pdn0    = 1'b0;
    logic          pdn1    = 1'b0;
    logic [DW-1:0] rx      = '0;
    logic [DW-1:0] q0, q1, bus;
    logic          oe0, coe0, c0, lk0;
    logic          oe1, coe1, c1, lk1;
    int            nchk  = 0;
    int            nfail = 0;
    int            clash = 0;

    always #10 if (ref_run) ref_clk = ~ref_clk;   // 50 MHz while running
    always #4 mon_clk = ~mon_clk;

    rx_out_gate #(.LOCK_CYCLES(L), .STALL_LIMIT(SL), .STROBE_FALL(1'b0)) u0 (
        .ref_clk(ref_clk), .mon_clk(mon_clk), .rst_n(rst_n), .pdn_n(pdn0),
        .rx_data(rx), .q_data(q0), .q_data_oe(oe0), .q_clk(c0),
        .q_clk_oe(coe0), .locked(lk0)
    );
    rx_out_gate #(.LOCK_CYCLES(L), .STALL_LIMIT(SL), .STROBE_FALL(1'b1)) u1 (
        .ref_clk(ref_clk), .mon_clk(mon_clk), .rst_n(rst_n), .pdn_n(pdn1),
        .rx_data(rx), .q_data(q1), .q_data_oe(oe1), .q_clk(c1),
        .q_clk_oe(coe1), .locked(lk1)
    );

    always_comb bus = oe0 ? q0 : (oe1 ? q1 : 'z);

    // R9: sample enables at odd nanoseconds, clear of every clock edge.
    initial begin
        #1;
        forever begin
            if (oe0 && oe1) clash++;
            #2;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge ref_clk);
        #5;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        if (i < DW) return DW'(1) << i;
        return DW'((i * 32'h9E3779B1) >> 5);
    endfunction

    task automatic set_pdn(input int w, input logic v);
        if (w == 0) pdn0 = v; else pdn1 = v;
    endtask

    // R3, R4: power up instance w and follow the count edge by edge.
    task automatic acquire(input int w, input string tag);
        set_pdn(w, 1'b1);
        for (int e = 1; e <= 2 + L; e++) begin
            rx = ~pat(e);
            tick();
            chk({tag, " R3 enable"}, (w == 0) ? oe0 : oe1, (e >= 2));
            if (e < 2 + L) begin
                chk({tag, " R4 not yet locked"}, (w == 0) ? lk0 : lk1, 1'b0);
                if (e >= 2) begin
                    chk({tag, " R3 data low"}, (w == 0) ? q0 : q1, '0);
                    chk({tag, " R3 clock low"}, (w == 0) ? c0 : c1, 1'b0);
                end
            end else begin
                chk({tag, " R4 locked"}, (w == 0) ? lk0 : lk1, 1'b1);
            end
        end
    endtask

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
    end

    initial begin
        int n;
        logic got;
        repeat (5) tick();
        chk("R10 reset oe0", oe0, 1'b0);
        chk("R1 reset clk oe0", coe0, 1'b0);
        chk("R1 reset lock1", lk1, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R1 powered down oe1", oe1, 1'b0);

        acquire(0, "u0");

        // R5: walking ones then scrambled words across all lanes.
        for (int i = 0; i < 64; i++) begin
            rx = pat(i);
            tick();
            chk("R5 data u0", q0, pat(i));
        end

        // R6: rising-strobe variant inverts the reference.
        chk("R6 u0 q_clk ref high", c0, 1'b0);
        #10;
        chk("R6 u0 q_clk ref low", c0, 1'b1);
        tick();

        // R2: release without a clock edge.
        pdn0 = 1'b0;
        #2;
        chk("R2 oe0 released", oe0, 1'b0);
        chk("R2 clk oe0 released", coe0, 1'b0);
        chk("R2 lock0 cleared", lk0, 1'b0);
        tick();
        tick();
        chk("R1 oe0 stays off", oe0, 1'b0);

        acquire(1, "u1");
        for (int i = 0; i < 8; i++) begin
            rx = pat(40 + i);
            tick();
            chk("R5 data u1", q1, pat(40 + i));
            chk("R9 bus carries u1", bus, pat(40 + i));
        end

        // R6: falling-strobe variant follows the reference.
        chk("R6 u1 q_clk ref high", c1, 1'b1);
        #10;
        chk("R6 u1 q_clk ref low", c1, 1'b0);
        tick();

        // R7: power-down after lock, then a full count again.
        pdn1 = 1'b0;
        repeat (3) tick();
        chk("R7 lock1 cleared", lk1, 1'b0);
        acquire(1, "R7 relock");

        // R7: power-down in the middle of the count.
        pdn1 = 1'b0;
        repeat (3) tick();
        pdn1 = 1'b1;
        repeat (4) tick();
        pdn1 = 1'b0;
        repeat (3) tick();
        acquire(1, "R7 midcount");

        // R8: stop the reference clock in its low phase.
        @(negedge ref_clk);
        ref_run = 1'b0;
        #295;
        chk("R8 lock dropped", lk1, 1'b0);
        chk("R8 data low", q1, '0);
        chk("R8 clock low", c1, 1'b0);
        chk("R8 still driven", oe1, 1'b1);
        ref_run = 1'b1;
        for (int i = 0; i < L + 3; i++) tick();
        chk("R8 count restarted", lk1, 1'b0);
        got = 1'b0;
        n = 0;
        while (!got && n < 40) begin
            tick();
            got = lk1;
            n++;
        end
        chk("R8 relocked", got, 1'b1);
        rx = pat(7);
        tick();
        chk("R8 data live again", q1, pat(7));

        // R10: synchronous reset while locked.
        rst_n = 1'b0;
        tick();
        chk("R10 lock cleared", lk1, 1'b0);
        chk("R10 enable cleared", oe1, 1'b0);
        rst_n = 1'b1;
        pdn1 = 1'b0;
        tick();
        acquire(1, "R10 restart");

        chk("R9 no overlap of enables", clash, 0);
        report();
    end
endmodule